// File: doc/BRIEF.md
# Interrupt Request Controller with Fast-Request Routing

This block gathers 48 interrupt request lines and presents them to a processor as two outputs: a normal request (`irqOut`) and a fast request (`fiqOut`). Each source has its own mask bit and its own sensitivity bit, which selects edge or level mode. Each source also has a software injection bit that makes the source look asserted without any activity on its pin. Software uses the pending status registers to find the sources that need service. It acknowledges edge-latched sources by writing ones to the acknowledge word. It can route any one source, chosen by number, to the fast output in place of the normal one.

Software reaches the registers through a single-cycle port with valid, write, address and data signals. Read data is registered and appears one cycle after the read is presented. Sources 0 to 31 live in the first 32-bit word of each register group. Sources 32 to 47 live in the low 16 bits of a second word at byte offset +4. The mask and injection groups each have two alias words. A write to the +0x20 alias sets the bits written as 1, and a write to the +0x40 alias clears them. In both cases bits written as 0 leave the register unchanged.

Top module: `intr_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, the sensitivity, injection and pending state are 0, the fast-source number is 0, and both `irqOut` and `fiqOut` are low.
- R2: Source i is bit i%32 of word i/32 in every group, and word 1 sits at group offset +4. Bits 16–31 of word 1 read as 0 and ignore writes. Word indices 2 to 7 read as 0.
- R3: A write to the mask word (0x000/0x004) replaces that word. A mask bit of 1 disables its source, so writing all ones keeps both outputs low.
- R4: Writes to the set alias (mask 0x020/0x024, injection 0x0E0/0x0E4) set only the bits written as 1. Writes to the clear alias (mask 0x040/0x044, injection 0x100/0x104) clear only the bits written as 1. Alias reads return the register itself, except that 0x100/0x104 read as status.
- R5: An injection bit that is 1 (group 0x0C0) makes its source behave as if its input were high. The injection bits are ORed with the raw inputs.
- R6: With sensitivity bit 0 (level mode, group 0x060), a source is pending exactly while its raw input OR its injection bit is 1. An acknowledge leaves it pending.
- R7: With sensitivity bit 1 (edge mode), a source becomes pending on a rising edge of its raw input OR its injection bit, and stays pending until a 1 is written to its bit in the acknowledge group (0x160/0x164). Bits written as 0 have no effect. If an acknowledge and a new rising edge reach the same source in the same cycle, the source stays pending.
- R8: The normal status words (read at 0x100/0x104) show the sources that are pending and unmasked, leaving out the fast-routed source. `irqOut` is the OR of those bits and is registered, so it rises on the first clock edge after the status becomes nonzero.
- R9: The fast-source register (0x180, word 0 only) holds the low 7 bits of the written data. The fast status words (0x140/0x144) show only the selected source when it is pending and unmasked, and `fiqOut` is their registered OR. A selection of 48 or more routes no source, and `fiqOut` stays low.
- R10: Read data is updated one cycle after a read is presented and holds its value until the next read. Addresses in unmapped groups read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address; bits 1:0 are ignored |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| srcIn | input | 48 | Raw interrupt request lines |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Two functions can land on the same edge-mode source in the same clock cycle: a software acknowledge and a new rising edge on the raw input. The bench sets up this case on purpose. It presents the acknowledge write in the same cycle that it raises the input, then reads status to confirm that the new edge kept the source pending. The same race also comes up during randomized traffic, which mixes input toggles, injection changes and acknowledge writes. There a cycle-level reference model built from the requirements judges every output and every read.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_SEL_W = 3;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MASK,
    RD_SENSE,
    RD_STIM,
    RD_IRQST,
    RD_FIQST,
    RD_FIQSEL
  } rdSel_t;

  typedef struct packed {
    logic                  maskWr;
    logic                  maskSet;
    logic                  maskClr;
    logic                  senseWr;
    logic                  stimWr;
    logic                  stimSet;
    logic                  stimClr;
    logic                  ackWr;
    logic                  fiqSelWr;
    logic                  rdEn;
    rdSel_t                rdSel;
    logic [WORD_SEL_W-1:0] word;
  } ctrlStrobe_t;

endpackage

// File: rtl/intr_ctrl_decode.sv
module intr_ctrl_decode
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 48,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);

  localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned GRP_W     = ADDR_W - 5;

  // Group codes are byte offset / 0x20; alias spacing depends on them.
  localparam logic [GRP_W-1:0] GRP_MASK     = GRP_W'(0);
  localparam logic [GRP_W-1:0] GRP_MASK_SET = GRP_W'(1);
  localparam logic [GRP_W-1:0] GRP_MASK_CLR = GRP_W'(2);
  localparam logic [GRP_W-1:0] GRP_SENSE    = GRP_W'(3);
  localparam logic [GRP_W-1:0] GRP_STIM     = GRP_W'(6);
  localparam logic [GRP_W-1:0] GRP_STIM_SET = GRP_W'(7);
  localparam logic [GRP_W-1:0] GRP_STIM_CLR = GRP_W'(8);
  localparam logic [GRP_W-1:0] GRP_FIQ_ST   = GRP_W'(10);
  localparam logic [GRP_W-1:0] GRP_ACK      = GRP_W'(11);
  localparam logic [GRP_W-1:0] GRP_FIQ_SEL  = GRP_W'(12);

  logic [GRP_W-1:0]      grp;
  logic [WORD_SEL_W-1:0] wordIdx;
  logic                  wordOk;
  logic                  wrOk;
  logic                  firstWord;
  logic [1:0]            unusedAddrBits;

  assign grp            = regAddr[ADDR_W-1:5];
  assign wordIdx        = regAddr[4:2];
  assign wordOk         = int'(wordIdx) < NUM_WORDS;
  assign wrOk           = regValid & regWrite & wordOk;
  assign firstWord      = (wordIdx == '0);
  assign unusedAddrBits = regAddr[1:0];

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    strobe.word  = wordIdx;
    strobe.rdEn  = regValid & ~regWrite;
    case (grp)
      GRP_MASK: begin
        strobe.maskWr = wrOk;
        if (wordOk) strobe.rdSel = RD_MASK;
      end
      GRP_MASK_SET: begin
        strobe.maskSet = wrOk;
        if (wordOk) strobe.rdSel = RD_MASK;
      end
      GRP_MASK_CLR: begin
        strobe.maskClr = wrOk;
        if (wordOk) strobe.rdSel = RD_MASK;
      end
      GRP_SENSE: begin
        strobe.senseWr = wrOk;
        if (wordOk) strobe.rdSel = RD_SENSE;
      end
      GRP_STIM: begin
        strobe.stimWr = wrOk;
        if (wordOk) strobe.rdSel = RD_STIM;
      end
      GRP_STIM_SET: begin
        strobe.stimSet = wrOk;
        if (wordOk) strobe.rdSel = RD_STIM;
      end
      GRP_STIM_CLR: begin
        // Shared offset: writes clear injection, reads return status.
        strobe.stimClr = wrOk;
        if (wordOk) strobe.rdSel = RD_IRQST;
      end
      GRP_FIQ_ST: begin
        if (wordOk) strobe.rdSel = RD_FIQST;
      end
      GRP_ACK: begin
        strobe.ackWr = wrOk;
      end
      GRP_FIQ_SEL: begin
        strobe.fiqSelWr = wrOk & firstWord;
        if (firstWord) strobe.rdSel = RD_FIQSEL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/intr_ctrl_datapath.sv
module intr_ctrl_datapath
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [WORD_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [WORD_W-1:0]  regRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int unsigned SEL_W = $clog2(NUM_SRC) + 1;
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] maskReg, senseReg, stimReg, edgePend, prevReq;
  logic [SEL_W-1:0]   fiqSelReg;

  logic [NUM_SRC-1:0] wrBits, wordEn, ackBits;
  logic [NUM_SRC-1:0] maskNext, stimNext, senseNext;
  logic [NUM_SRC-1:0] req, rise, effPend, unmasked, selOneHot;
  logic [NUM_SRC-1:0] irqStat, fiqStat;
  logic [NUM_SRC-1:0] rdVec;
  logic [WORD_W-1:0]  rdWord;

  // Spread the bus word onto source positions of the addressed word.
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      wordEn[i] = (int'(strobe.word) == i / WORD_W);
      wrBits[i] = wordEn[i] & regWdata[i % WORD_W];
    end
  end

  assign ackBits = strobe.ackWr ? wrBits : '0;

  always_comb begin
    maskNext = maskReg;
    if (strobe.maskWr)       maskNext = (maskReg & ~wordEn) | wrBits;
    else if (strobe.maskSet) maskNext = maskReg | wrBits;
    else if (strobe.maskClr) maskNext = maskReg & ~wrBits;
  end

  always_comb begin
    stimNext = stimReg;
    if (strobe.stimWr)       stimNext = (stimReg & ~wordEn) | wrBits;
    else if (strobe.stimSet) stimNext = stimReg | wrBits;
    else if (strobe.stimClr) stimNext = stimReg & ~wrBits;
  end

  always_comb begin
    senseNext = senseReg;
    if (strobe.senseWr) senseNext = (senseReg & ~wordEn) | wrBits;
  end

  // Request path: raw OR injection, edge detect, mode select.
  assign req     = srcIn | stimReg;
  assign rise    = req & ~prevReq;
  assign effPend = (senseReg & edgePend) | (~senseReg & req);

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gSel
      assign selOneHot[g] = (fiqSelReg == SEL_W'(g));
    end
  endgenerate

  assign unmasked = effPend & ~maskReg;
  assign irqStat  = unmasked & ~selOneHot;
  assign fiqStat  = unmasked & selOneHot;

  // Read mux.
  always_comb begin
    rdVec = '0;
    case (strobe.rdSel)
      RD_MASK:  rdVec = maskReg;
      RD_SENSE: rdVec = senseReg;
      RD_STIM:  rdVec = stimReg;
      RD_IRQST: rdVec = irqStat;
      RD_FIQST: rdVec = fiqStat;
      default:  rdVec = '0;
    endcase
    rdWord = '0;
    for (int b = 0; b < WORD_W; b++) begin
      int idx;
      idx = int'(strobe.word) * WORD_W + b;
      if (idx < NUM_SRC) rdWord[b] = rdVec[idx[IDX_W-1:0]];
    end
    if (strobe.rdSel == RD_FIQSEL) rdWord = WORD_W'(fiqSelReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '1;
      senseReg  <= '0;
      stimReg   <= '0;
      edgePend  <= '0;
      prevReq   <= '0;
      fiqSelReg <= '0;
      irqOut    <= 1'b0;
      fiqOut    <= 1'b0;
      regRdata  <= '0;
    end else begin
      maskReg  <= maskNext;
      senseReg <= senseNext;
      stimReg  <= stimNext;
      prevReq  <= req;
      // A new edge wins over an acknowledge in the same cycle.
      edgePend <= senseReg & (rise | (edgePend & ~ackBits));
      if (strobe.fiqSelWr) fiqSelReg <= regWdata[SEL_W-1:0];
      irqOut <= |irqStat;
      fiqOut <= |fiqStat;
      if (strobe.rdEn) regRdata <= rdWord;
    end
  end

  // Assertions next to the logic they guard.
  assert_fiq_none_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fiqSelReg >= SEL_W'(NUM_SRC)) |=> !fiqOut);

  assert_all_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (&maskReg) |=> (!irqOut && !fiqOut));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackWr |=> ((edgePend & $past(ackBits & ~rise)) == '0));

  assert_edge_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(rise & senseReg)) |=> (|edgePend));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet |=> ((maskReg & $past(wrBits)) == $past(wrBits)));

  assert_stim_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stimClr |=> ((stimReg & $past(wrBits)) == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(regRdata));

endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 48,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);

  ctrlStrobe_t strobe;

  intr_ctrl_decode #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  intr_ctrl_datapath #(
    .NUM_SRC(NUM_SRC)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regWdata(regWdata),
    .srcIn   (srcIn),
    .regRdata(regRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: tb/intr_ctrl_bench.sv
module intr_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [47:0] srcIn = '0;
  logic        irqOut, fiqOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_ctrl u_intr_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // ---------------- reference model built from the requirements ----------
  logic [47:0] mMask, mSense, mStim, mPend, mPrev;
  logic [6:0]  mSel;
  logic        mIrq, mFiq;
  logic [31:0] mRd;

  function automatic logic [47:0] spread(input logic [11:0] a, input logic [31:0] d);
    logic [47:0] v = '0;
    if (a[4:2] == 3'd0) v[31:0] = d;
    else if (a[4:2] == 3'd1) v[47:32] = d[15:0];
    return v;
  endfunction

  function automatic logic [47:0] wordBits(input logic [11:0] a);
    return spread(a, 32'hFFFF_FFFF);
  endfunction

  function automatic logic [47:0] selVec(input logic [6:0] s);
    logic [47:0] v = '0;
    if (s < 7'd48) v[s[5:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [47:0] effPend();
    logic [47:0] r = srcIn | mStim;
    return (mSense & mPend) | (~mSense & r);
  endfunction

  function automatic logic [31:0] pickWord(input logic [11:0] a, input logic [47:0] v);
    if (a[4:2] == 3'd0) return v[31:0];
    if (a[4:2] == 3'd1) return {16'h0, v[47:32]};
    return 32'h0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    logic [47:0] u = effPend() & ~mMask;
    case (a[11:5])
      7'd0, 7'd1, 7'd2: return pickWord(a, mMask);
      7'd3:             return pickWord(a, mSense);
      7'd6, 7'd7:       return pickWord(a, mStim);
      7'd8:             return pickWord(a, u & ~selVec(mSel));
      7'd10:            return pickWord(a, u & selVec(mSel));
      7'd12:            return (a[4:2] == 3'd0) ? {25'h0, mSel} : 32'h0;
      default:          return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask <= '1; mSense <= '0; mStim <= '0; mPend <= '0; mPrev <= '0;
      mSel <= '0; mIrq <= 1'b0; mFiq <= 1'b0; mRd <= '0;
    end else begin
      logic [47:0] rq, rs, u, wb, ack;
      rq  = srcIn | mStim;
      rs  = rq & ~mPrev;
      u   = effPend() & ~mMask;
      wb  = spread(regAddr, regWdata);
      ack = (regValid && regWrite && regAddr[11:5] == 7'd11) ? wb : '0;
      mIrq  <= |(u & ~selVec(mSel));
      mFiq  <= |(u & selVec(mSel));
      mPrev <= rq;
      mPend <= mSense & (rs | (mPend & ~ack));
      if (regValid && !regWrite) mRd <= modelRead(regAddr);
      if (regValid && regWrite) begin
        case (regAddr[11:5])
          7'd0:  mMask  <= (mMask & ~wordBits(regAddr)) | wb;
          7'd1:  mMask  <= mMask | wb;
          7'd2:  mMask  <= mMask & ~wb;
          7'd3:  mSense <= (mSense & ~wordBits(regAddr)) | wb;
          7'd6:  mStim  <= (mStim & ~wordBits(regAddr)) | wb;
          7'd7:  mStim  <= mStim | wb;
          7'd8:  mStim  <= mStim & ~wb;
          7'd12: if (regAddr[4:2] == 3'd0) mSel <= regWdata[6:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finishRun();
    end
  end

  // ---------------- stimulus ----------------
  logic [11:0] addrList [22] = '{12'h000, 12'h004, 12'h020, 12'h024, 12'h040, 12'h044,
                                 12'h060, 12'h064, 12'h0C0, 12'h0C4, 12'h0E0, 12'h0E4,
                                 12'h100, 12'h104, 12'h140, 12'h144, 12'h160, 12'h164,
                                 12'h180, 12'h184, 12'h1A0, 12'h008};

  initial begin
    logic [31:0] rd;
    bit lastRead;
    void'($urandom(32'd20240611));
    idle(2);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqOut", {31'h0, irqOut}, 32'h0);
    check("R1 fiqOut", {31'h0, fiqOut}, 32'h0);
    busRead(12'h000, rd); check("R1 mask word0", rd, 32'hFFFF_FFFF);
    busRead(12'h004, rd); check("R1 R2 mask word1", rd, 32'h0000_FFFF);
    busRead(12'h060, rd); check("R1 sense", rd, 32'h0);
    busRead(12'h0C0, rd); check("R1 inject", rd, 32'h0);
    busRead(12'h180, rd); check("R1 fast select", rd, 32'h0);

    // R2 upper bits of word 1 ignore writes
    busWrite(12'h004, 32'h0000_0000);
    busWrite(12'h004, 32'hFFFF_0000);
    busRead(12'h004, rd); check("R2 word1 upper ignored", rd, 32'h0);
    busWrite(12'h004, 32'hFFFF_FFFF);

    // R9 select none, then R3/R6/R8 level source 0
    busWrite(12'h180, 32'h0000_003F);
    busRead(12'h180, rd); check("R9 select readback", rd, 32'h3F);
    busWrite(12'h000, 32'hFFFF_FFFE);
    busRead(12'h000, rd); check("R3 mask replace", rd, 32'hFFFF_FFFE);
    @(negedge clk); srcIn[0] = 1'b1;
    @(negedge clk); check("R8 irqOut one edge after level", {31'h0, irqOut}, 32'h1);
    check("R9 no fast source", {31'h0, fiqOut}, 32'h0);
    busRead(12'h100, rd); check("R8 status word0", rd, 32'h1);
    busWrite(12'h160, 32'h1);
    busRead(12'h100, rd); check("R6 ack no effect in level", rd, 32'h1);
    srcIn[0] = 1'b0; idle(2);
    check("R6 level drops", {31'h0, irqOut}, 32'h0);

    // R3 all masked with live level source
    srcIn[0] = 1'b1;
    busWrite(12'h000, 32'hFFFF_FFFF); idle(2);
    check("R3 all masked", {31'h0, irqOut}, 32'h0);
    srcIn[0] = 1'b0;

    // R4/R5 injection on source 35
    busWrite(12'h0E4, 32'h8);
    busWrite(12'h044, 32'h8);
    busRead(12'h004, rd); check("R4 mask clear alias", rd, 32'h0000_FFF7);
    busRead(12'h104, rd); check("R5 R2 injected status word1", rd, 32'h8);
    check("R5 irqOut from injection", {31'h0, irqOut}, 32'h1);
    busWrite(12'h024, 32'h0);
    busRead(12'h004, rd); check("R4 zero bits unchanged", rd, 32'h0000_FFF7);
    busWrite(12'h104, 32'h8);
    busRead(12'h0C4, rd); check("R4 inject clear alias", rd, 32'h0);
    idle(1);
    check("R5 injection removed", {31'h0, irqOut}, 32'h0);

    // R7 edge source 1
    busWrite(12'h060, 32'h2);
    busWrite(12'h040, 32'h2);
    @(negedge clk); srcIn[1] = 1'b1;
    @(negedge clk); srcIn[1] = 1'b0;
    busRead(12'h100, rd); check("R7 edge latched", rd, 32'h2);
    busWrite(12'h160, 32'h0);
    busRead(12'h100, rd); check("R7 zero ack no effect", rd, 32'h2);
    busWrite(12'h160, 32'h2);
    busRead(12'h100, rd); check("R7 ack clears", rd, 32'h0);
    idle(1);
    check("R7 irqOut low after ack", {31'h0, irqOut}, 32'h0);

    // R7 simultaneous acknowledge and new edge
    @(negedge clk); srcIn[1] = 1'b1;
    @(negedge clk); srcIn[1] = 1'b0; idle(1);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = 12'h160; regWdata = 32'h2; srcIn[1] = 1'b1;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    busRead(12'h100, rd); check("R7 edge wins over ack", rd, 32'h2);
    srcIn[1] = 1'b0;
    busWrite(12'h160, 32'h2);

    // R9 route source 1 to fast output
    busWrite(12'h180, 32'h1);
    @(negedge clk); srcIn[1] = 1'b1;
    @(negedge clk); srcIn[1] = 1'b0; idle(1);
    check("R9 fiqOut", {31'h0, fiqOut}, 32'h1);
    check("R8 irqOut excludes fast source", {31'h0, irqOut}, 32'h0);
    busRead(12'h140, rd); check("R9 fast status", rd, 32'h2);
    busRead(12'h100, rd); check("R8 status excludes fast", rd, 32'h0);
    busWrite(12'h160, 32'h2); idle(1);
    check("R9 fiqOut cleared", {31'h0, fiqOut}, 32'h0);

    // R10 unmapped and hold
    busRead(12'h1A0, rd); check("R10 unmapped", rd, 32'h0);
    busRead(12'h180, rd);
    busRead(12'h008, rd); check("R10 R2 word2 reads zero", rd, 32'h0);
    idle(3); check("R10 read data holds", regRdata, 32'h0);

    // Randomized traffic judged by the model (R3..R10)
    lastRead = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      check("R8 irqOut random", {31'h0, irqOut}, {31'h0, mIrq});
      check("R9 fiqOut random", {31'h0, fiqOut}, {31'h0, mFiq});
      if (lastRead) check("R10 random read", regRdata, mRd);
      regValid = 1'b0; regWrite = 1'b0; lastRead = 1'b0;
      case ($urandom % 4)
        0: srcIn = srcIn ^ (48'(1) << ($urandom % 48));
        1: begin
          regValid = 1'b1; regWrite = 1'b1;
          regAddr = addrList[$urandom % 22];
          regWdata = ($urandom % 2) ? $urandom : (32'h1 << ($urandom % 32));
          if (regAddr == 12'h180) regWdata = $urandom % 56;
        end
        2: begin
          regValid = 1'b1; regWrite = 1'b0;
          regAddr = addrList[$urandom % 22];
          lastRead = 1'b1;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    regValid = 1'b0;
    if (lastRead) check("R10 random read", regRdata, mRd);

    done = 1'b1;
    finishRun();
  end

endmodule